// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports, called A and B, in both directions at once. Each direction has a storage stage whose behaviour is set by two control inputs for that direction: a latch enable and a direction clock. While the latch enable is high the stage follows its input. While it is low the stage holds its value, except that a high-to-low transition of the direction clock loads a new value. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low. The ports are modelled with separate input, output and per-bit output-enable vectors. Each input bit has a "driven" flag, and a bus-hold keeper supplies the last driven level for any bit whose flag is low.

The block runs on one fast system clock. The direction clocks and latch enables are asynchronous to it, so each passes through a two-stage synchronizer. A per-direction control state machine then tracks the synchronized levels. It has three states. LM_FLOW is entered whenever the synchronized latch enable is high. LM_HOLD_HI and LM_HOLD_LO are entered when the latch enable is low, according to the synchronized direction clock level. The state machine can take these transitions:
- Any state moves to LM_FLOW when the latch enable is high. The stage loads every cycle while this holds.
- LM_FLOW moves to LM_HOLD_HI or LM_HOLD_LO when the latch enable drops. No load takes place.
- LM_HOLD_LO moves to LM_HOLD_HI when the clock rises. No load takes place.
- LM_HOLD_HI moves to LM_HOLD_LO when the clock falls. This is the capture transition and the only one that loads data in a hold state.

Top module: `bidir_xcvr`

## Requirements
- R1: While `le_ab` is high, `b_out` equals the effective A input (keeper-resolved) of one system cycle earlier, once the enable has passed the synchronizer.
- R2: While `le_ab` is low and `clk_ab` keeps a steady level, `b_out` keeps its value whatever `a_in` does.
- R3: While `le_ab` is low, a high-to-low transition of `clk_ab` loads the effective A input into the A-to-B stage, and the new value appears on `b_out`.
- R4: While `le_ab` is low, a low-to-high transition of `clk_ab` leaves `b_out` unchanged.
- R5: `b_oe` is all ones one cycle after `oe_ab` is sampled high, and all zeros one cycle after it is sampled low (active-high enable).
- R6: `a_oe` is all ones one cycle after `oe_ba_n` is sampled low, and all zeros one cycle after it is sampled high (active-low enable).
- R7: The B-to-A direction follows the rules of R1 to R4 on its own, using `le_ba`, `clk_ba`, `b_in` and `b_drv`, with `a_out` as its output. It is not affected by the A-to-B controls.
- R8: A bit whose `*_drv` flag is low contributes the last level it had while its flag was high. The keeper for a bit changes only in cycles where that bit's flag is high. Each bit is handled independently.
- R9: While the latch enable is high, a falling edge on the direction clock has no effect beyond following the live input.
- R10: While `rst` is high, `a_out`, `b_out`, `a_oe` and `b_oe` are all zero, and the keepers are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Level seen on the A port pins |
| a_drv | input | 18 | Per-bit flag: A pin is actively driven from outside |
| b_in | input | 18 | Level seen on the B port pins |
| b_drv | input | 18 | Per-bit flag: B pin is actively driven from outside |
| le_ab | input | 1 | A-to-B latch enable (high = follow) |
| clk_ab | input | 1 | A-to-B direction clock, loads on falling edge |
| oe_ab | input | 1 | A-to-B output enable, active high |
| le_ba | input | 1 | B-to-A latch enable (high = follow) |
| clk_ba | input | 1 | B-to-A direction clock, loads on falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | Value the block would drive on the A port |
| a_oe | output | 18 | Per-bit drive enable for the A port |
| b_out | output | 18 | Value the block would drive on the B port |
| b_oe | output | 18 | Per-bit drive enable for the B port |

## Verification
Directed patterns come first, applied to each direction in turn:
- A data change while following, which tests R1 against R2.
- A data change while holding at either clock level.
- A rising clock edge followed by a falling one, which separates R4 from R3.
- A falling edge while following.
- Driven bits followed by undriven bits with conflicting pin levels, which shows whether the keeper or the live pin reaches the stage.

A long random walk then changes one control or data group per step and compares both outputs and both enable vectors against a bench model of the stage rules. Because only one group changes per step, a swapped enable polarity, a capture on the wrong edge, or leakage between the two directions each shows up as a distinct mismatch.

// File: rtl/bxcvr_pkg.sv
`timescale 1ns/1ps
package bxcvr_pkg;
    parameter int DATA_W      = 18;
    parameter int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        LM_HOLD_LO = 2'd0,
        LM_HOLD_HI = 2'd1,
        LM_FLOW    = 2'd2
    } lane_mode_e;
endpackage

// File: rtl/xcv_sync.sv
`timescale 1ns/1ps
module xcv_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sh [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= '0;
                else     sh[g] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[g] <= '0;
                else     sh[g] <= sh[g-1];
            end
        end
    end

    assign q_o = sh[STAGES-1];
endmodule

// File: rtl/xcv_keeper.sv
`timescale 1ns/1ps
module xcv_keeper #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] drv_i,
    output logic [W-1:0] kept_o,
    output logic [W-1:0] eff_o
);
    logic [W-1:0] kept_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)           kept_q[b] <= 1'b0;
            else if (drv_i[b]) kept_q[b] <= pin_i[b];
        end
        assign eff_o[b] = drv_i[b] ? pin_i[b] : kept_q[b];
    end

    assign kept_o = kept_q;
endmodule

// File: rtl/xcv_lane.sv
`timescale 1ns/1ps
module xcv_lane
    import bxcvr_pkg::*;
#(
    parameter int W    = 18,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le_i,
    input  logic         ck_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o,
    output lane_mode_e   mode_o
);
    logic [1:0]   ctl_s;
    logic         le_s;
    logic         ck_s;
    lane_mode_e   state_q;
    lane_mode_e   state_nx;
    logic         take;
    logic [W-1:0] store_q;

    xcv_sync #(.W(2), .STAGES(SYNC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({le_i, ck_i}),
        .q_o (ctl_s)
    );

    assign le_s = ctl_s[1];
    assign ck_s = ctl_s[0];

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= LM_HOLD_LO;
        else     state_q <= state_nx;
    end

    // next state and load decision
    always_comb begin
        state_nx = state_q;
        take     = 1'b0;
        if (le_s) begin
            state_nx = LM_FLOW;
            take     = 1'b1;
        end else begin
            unique case (state_q)
                LM_FLOW:    state_nx = ck_s ? LM_HOLD_HI : LM_HOLD_LO;
                LM_HOLD_HI: if (!ck_s) begin
                                state_nx = LM_HOLD_LO;
                                take     = 1'b1;
                            end
                LM_HOLD_LO: if (ck_s) state_nx = LM_HOLD_HI;
                default:    state_nx = LM_HOLD_LO;
            endcase
        end
    end

    // output storage
    always_ff @(posedge clk) begin
        if (rst)       store_q <= '0;
        else if (take) store_q <= din_i;
    end

    assign dout_o = store_q;
    assign mode_o = state_q;
endmodule

// File: rtl/bidir_xcvr.sv
`timescale 1ns/1ps
module bidir_xcvr
    import bxcvr_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int SYNC = SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] a_drv,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] b_drv,
    input  logic         le_ab,
    input  logic         clk_ab,
    input  logic         oe_ab,
    input  logic         le_ba,
    input  logic         clk_ba,
    input  logic         oe_ba_n,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic [W-1:0] a_kept, a_eff;
    logic [W-1:0] b_kept, b_eff;
    lane_mode_e   ab_mode, ba_mode;
    logic         en_b_q, en_a_q;

    xcv_keeper #(.W(W)) u_keep_a (
        .clk (clk), .rst (rst), .pin_i (a_in), .drv_i (a_drv),
        .kept_o (a_kept), .eff_o (a_eff)
    );

    xcv_keeper #(.W(W)) u_keep_b (
        .clk (clk), .rst (rst), .pin_i (b_in), .drv_i (b_drv),
        .kept_o (b_kept), .eff_o (b_eff)
    );

    xcv_lane #(.W(W), .SYNC(SYNC)) u_lane_ab (
        .clk (clk), .rst (rst), .le_i (le_ab), .ck_i (clk_ab),
        .din_i (a_eff), .dout_o (b_out), .mode_o (ab_mode)
    );

    xcv_lane #(.W(W), .SYNC(SYNC)) u_lane_ba (
        .clk (clk), .rst (rst), .le_i (le_ba), .ck_i (clk_ba),
        .din_i (b_eff), .dout_o (a_out), .mode_o (ba_mode)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_b_q <= 1'b0;
            en_a_q <= 1'b0;
        end else begin
            en_b_q <= oe_ab;
            en_a_q <= ~oe_ba_n;
        end
    end

    assign b_oe = {W{en_b_q}};
    assign a_oe = {W{en_a_q}};
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker
    import bxcvr_pkg::*;
#(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic         oe_ab,
    input logic         oe_ba_n,
    input logic [W-1:0] a_drv,
    input logic [W-1:0] b_drv,
    input logic [W-1:0] a_kept,
    input logic [W-1:0] b_kept,
    input logic [W-1:0] a_eff,
    input logic [W-1:0] b_eff,
    input lane_mode_e   ab_mode,
    input lane_mode_e   ba_mode,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic [W-1:0] a_oe,
    input logic [W-1:0] b_oe
);
    assert_flow_ab_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ab_mode == LM_FLOW) |-> (b_out == $past(a_eff)));

    assert_hold_ab_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ab_mode != LM_FLOW &&
         !(ab_mode == LM_HOLD_LO && $past(ab_mode) == LM_HOLD_HI)) |-> $stable(b_out));

    assert_capture_ab_R3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ab_mode == LM_HOLD_LO && $past(ab_mode) == LM_HOLD_HI)
        |-> (b_out == $past(a_eff)));

    assert_oe_b_on_R5: assert property (@(posedge clk) disable iff (rst)
        oe_ab |=> (b_oe == '1));

    assert_oe_b_off_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_ab |=> (b_oe == '0));

    assert_oe_a_on_R6: assert property (@(posedge clk) disable iff (rst)
        !oe_ba_n |=> (a_oe == '1));

    assert_oe_a_off_R6: assert property (@(posedge clk) disable iff (rst)
        oe_ba_n |=> (a_oe == '0));

    assert_flow_ba_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ba_mode == LM_FLOW) |-> (a_out == $past(b_eff)));

    assert_hold_ba_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ba_mode != LM_FLOW &&
         !(ba_mode == LM_HOLD_LO && $past(ba_mode) == LM_HOLD_HI)) |-> $stable(a_out));

    assert_keep_a_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((a_kept ^ $past(a_kept)) & ~$past(a_drv)) == '0));

    assert_keep_b_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (((b_kept ^ $past(b_kept)) & ~$past(b_drv)) == '0));

    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (a_out == '0 && b_out == '0 && a_oe == '0 && b_oe == '0
                        && a_kept == '0 && b_kept == '0));
endmodule

bind bidir_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .oe_ab   (oe_ab),
    .oe_ba_n (oe_ba_n),
    .a_drv   (a_drv),
    .b_drv   (b_drv),
    .a_kept  (a_kept),
    .b_kept  (b_kept),
    .a_eff   (a_eff),
    .b_eff   (b_eff),
    .ab_mode (ab_mode),
    .ba_mode (ba_mode),
    .a_out   (a_out),
    .b_out   (b_out),
    .a_oe    (a_oe),
    .b_oe    (b_oe)
);

// File: tb/bidir_xcvr_test.sv
`timescale 1ns/1ps
module bidir_xcvr_test;
    localparam int W = 18;
    localparam int SETTLE = 6;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, a_drv = '1, b_in = '0, b_drv = '1;
    logic         le_ab = 1'b0, clk_ab = 1'b0, oe_ab = 1'b0;
    logic         le_ba = 1'b0, clk_ba = 1'b0, oe_ba_n = 1'b1;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model state
    logic [W-1:0] ka = '0, kb = '0, sab = '0, sba = '0;
    logic         pck_ab = 1'b0, pck_ba = 1'b0;

    bidir_xcvr uut (
        .clk (clk), .rst (rst),
        .a_in (a_in), .a_drv (a_drv), .b_in (b_in), .b_drv (b_drv),
        .le_ab (le_ab), .clk_ab (clk_ab), .oe_ab (oe_ab),
        .le_ba (le_ba), .clk_ba (clk_ba), .oe_ba_n (oe_ba_n),
        .a_out (a_out), .a_oe (a_oe), .b_out (b_out), .b_oe (b_oe)
    );

    always #4ns clk = ~clk;

    function automatic logic [W-1:0] resolve(logic [W-1:0] pin, logic [W-1:0] drv,
                                             logic [W-1:0] kept);
        return (drv & pin) | (~drv & kept);
    endfunction

    function automatic logic [W-1:0] next_keep(logic [W-1:0] pin, logic [W-1:0] drv,
                                               logic [W-1:0] kept);
        return (drv & pin) | (~drv & kept);
    endfunction

    function automatic logic [W-1:0] next_store(logic le, logic ck_old, logic ck_new,
                                                logic [W-1:0] din, logic [W-1:0] cur);
        if (le || (ck_old && !ck_new)) return din;
        return cur;
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply model, let inputs settle, then compare all outputs
    task automatic step(string rb, string ra, string rob, string roa);
        ka  = next_keep(a_in, a_drv, ka);
        kb  = next_keep(b_in, b_drv, kb);
        sab = next_store(le_ab, pck_ab, clk_ab, resolve(a_in, a_drv, ka), sab);
        sba = next_store(le_ba, pck_ba, clk_ba, resolve(b_in, b_drv, kb), sba);
        pck_ab = clk_ab;
        pck_ba = clk_ba;
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
        chk(rb,  b_out, sab);
        chk(ra,  a_out, sba);
        chk(rob, b_oe, {W{oe_ab}});
        chk(roa, a_oe, {W{~oe_ba_n}});
    endtask

    initial begin
        #(200000 * 8ns);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        // R10: outputs cleared while reset is held, even with enables asserted
        a_in = 18'h2A5A5; le_ab = 1'b1; oe_ab = 1'b1; oe_ba_n = 1'b0;
        b_in = 18'h15A5A; le_ba = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R10 b_out", b_out, '0);
        chk("R10 a_out", a_out, '0);
        chk("R10 b_oe", b_oe, '0);
        chk("R10 a_oe", a_oe, '0);
        rst = 1'b0;

        // R1 / R7 / R5 / R6: following mode in both directions
        step("R1", "R7", "R5", "R6");
        a_in = 18'h3C3C3; b_in = 18'h0F0F0;
        step("R1", "R7", "R5", "R6");

        // R2: latch closed, clock low and steady, data changes
        le_ab = 1'b0;
        step("R2", "R7", "R5", "R6");
        a_in = 18'h12345;
        step("R2", "R7", "R5", "R6");

        // R4: rising edge does not load
        clk_ab = 1'b1;
        step("R4", "R7", "R5", "R6");
        // R2: steady high, new data held off
        a_in = 18'h3FFFF;
        step("R2", "R7", "R5", "R6");
        // R3: falling edge loads
        clk_ab = 1'b0;
        step("R3", "R7", "R5", "R6");
        if (b_out !== 18'h3FFFF) begin
            errors++;
            $display("FAIL R3: actual=%h expected=%h", b_out, 18'h3FFFF);
        end
        checks++;

        // R9: falling edge while following only follows
        le_ab = 1'b1; a_in = 18'h00F0F;
        step("R9", "R7", "R5", "R6");
        clk_ab = 1'b1;
        step("R9", "R7", "R5", "R6");
        a_in = 18'h2AAAA; clk_ab = 1'b0;
        step("R9", "R7", "R5", "R6");

        // R8: undriven bits keep their last driven level
        a_in = 18'h3FFFF; a_drv = '1;
        step("R8", "R7", "R5", "R6");
        a_in = 18'h00000; a_drv = 18'h000FF;
        step("R8", "R7", "R5", "R6");
        chk("R8 kept", b_out, 18'h3FF00);
        a_drv = '0; a_in = 18'h15555;
        step("R8", "R7", "R5", "R6");

        // R5 / R6: enable polarity toggles
        oe_ab = 1'b0;
        step("R1", "R7", "R5", "R6");
        oe_ba_n = 1'b1;
        step("R1", "R7", "R5", "R6");
        oe_ab = 1'b1;
        step("R1", "R7", "R5", "R6");

        // R7: B-to-A hold and capture with A-to-B still following
        a_drv = '1;
        le_ba = 1'b0; clk_ba = 1'b1;
        step("R1", "R7", "R5", "R6");
        b_in = 18'h0BEEF;
        step("R1", "R7", "R5", "R6");
        clk_ba = 1'b0;
        step("R1", "R7", "R5", "R6");

        // random walk, one group changed per step
        for (int n = 0; n < 400; n++) begin
            case ($urandom % 7)
                0: begin a_in = W'($urandom); a_drv = W'($urandom | $urandom); end
                1: begin b_in = W'($urandom); b_drv = W'($urandom | $urandom); end
                2: clk_ab = ~clk_ab;
                3: clk_ba = ~clk_ba;
                4: le_ab = ~le_ab;
                5: le_ba = ~le_ba;
                default: begin oe_ab = ~oe_ab; oe_ba_n = W'($urandom) % 2 == 0; end
            endcase
            step("R1", "R7", "R5", "R6");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule